// File: doc/BRIEF.md
# I2C Bus Slave Controller

This block is an I2C target that sits on a small register bus next to a processor. It samples SCL and SDA through a synchroniser and detects START and STOP conditions, which set and clear a bus-busy flag. After a START it collects a 7-bit address and a direction bit. It compares the address with a programmable own address, and on a match it acknowledges and raises an interrupt.

Bytes in either direction pass through one data register. After the address acknowledge, and again after each byte's acknowledge clock, the controller pulls SCL low and keeps it low until software touches the data register. In transmit mode software writes the next byte. In receive mode software reads the received byte, or does a dummy read. A match flag in the status register tells software whether the pending interrupt came from an address match or from a finished byte. SDA and SCL are open-drain: each output enable pulls its line low when set.

Top module: `i2c_slave_ctrl`

## Requirements
- R1: A falling SDA while SCL is high (START) sets status bit 0 (busy).
- R2: A rising SDA while SCL is high (STOP) clears status bits 0 to 3, releases SDA and SCL, and returns the controller to idle.
- R3: After START, the first 8 bits sampled on SCL rising edges form the address frame, MSB first. Its upper 7 bits are compared with the own-address register (offset 3, bits 6:0, reset value 0x2A). On a match SDA is pulled low for the 9th clock. On a mismatch SDA and SCL are never driven and no interrupt is raised until the next START or STOP.
- R4: On a match, the 8th bit is latched into status bit 2 (1 = the master reads and the controller transmits).
- R5: An address match raises `irq` and sets status bit 1. Completion of a byte's acknowledge clock raises `irq` and clears status bit 1. Status bit 4 mirrors `irq`, and writing the status register (offset 1) with bit 4 set clears it.
- R6: In receive mode the byte is shifted in MSB first and stored in the data register (offset 2). On the 9th clock SDA is pulled low when control bit 1 (offset 0) is 0 and left released when it is 1.
- R7: After every address or byte event SCL is held low, shown in status bit 5. The hold ends only on a data register write with control bit 0 = 1, or a data register read with control bit 0 = 0. Any other register access leaves SCL held.
- R8: In transmit mode the byte written to the data register is driven MSB first. SDA changes only while SCL is low.
- R9: In transmit mode SDA is released for the 9th clock, and the master's acknowledge level is latched into status bit 3 (1 = no acknowledge).
- R10: A START in the middle of a byte drops that byte, leaves the data register unchanged, and restarts address reception.
- R11: After reset both line enables are low, `irq` is low, the status and control registers read 0, and the own address reads 0x2A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved master: SDA changes only while SCL is low, except for START and STOP. Each line also stays stable for several system clocks, so the synchroniser cannot reorder an SCL edge and an SDA edge. The bench master keeps every line change a dozen clocks away from the previous one, and it waits for SCL to actually rise, so it honours clock stretching. Repeated STARTs are issued only while the controller is receiving, never while it drives SDA.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_HOLD,
    ST_SKIP
  } eng_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;

  localparam int CTRL_TXM  = 0;
  localparam int CTRL_NACK = 1;

  localparam int SB_BUSY = 0;
  localparam int SB_HIT  = 1;
  localparam int SB_DIR  = 2;
  localparam int SB_RXNK = 3;
  localparam int SB_IRQ  = 4;
  localparam int SB_HOLD = 5;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '1;
        prev_q <= 1'b1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], din[i]};
        prev_q <= pipe_q[STAGES-1];
      end
    end

    assign lvl[i]  = pipe_q[STAGES-1];
    assign rise[i] = pipe_q[STAGES-1] & ~prev_q;
    assign fall[i] = ~pipe_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tx_mode,
  input  logic              nack_ctl,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              busy,
  output logic              dir,
  output logic              rx_nack,
  output logic              evt_addr,
  output logic              evt_byte,
  output logic              evt_stop,
  output logic              sda_oe,
  output logic              scl_oe
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  eng_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [DATA_W-1:0] data_d;
  logic              busy_q, busy_d;
  logic              dir_q, dir_d;
  logic              rxnk_q, rxnk_d;
  logic              sda_q, sda_d;
  logic              start_p, stop_p;

  assign start_p = sda_fall & scl_s;
  assign stop_p  = sda_rise & scl_s;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shf_d    = shf_q;
    data_d   = data_q;
    busy_d   = busy_q;
    dir_d    = dir_q;
    rxnk_d   = rxnk_q;
    sda_d    = sda_q;
    evt_addr = 1'b0;
    evt_byte = 1'b0;

    if (data_wr) begin
      data_d = wdata;
    end

    if (start_p) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      busy_d  = 1'b1;
      sda_d   = 1'b0;
    end else if (stop_p) begin
      state_d = ST_IDLE;
      busy_d  = 1'b0;
      dir_d   = 1'b0;
      rxnk_d  = 1'b0;
      sda_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            shf_d = {shf_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (shf_q[DATA_W-1:1] == own_addr) begin
              state_d = ST_AACK;
              dir_d   = shf_q[0];
              sda_d   = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_d    = 1'b0;
            state_d  = ST_HOLD;
            evt_addr = 1'b1;
          end
        end
        ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            shf_d = {shf_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            data_d  = shf_q;
            sda_d   = ~nack_ctl;
            state_d = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            sda_d    = 1'b0;
            state_d  = ST_HOLD;
            evt_byte = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sda_d   = 1'b0;
              state_d = ST_TACK;
            end else begin
              shf_d = {shf_q[DATA_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              sda_d = ~shf_q[DATA_W-2];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            rxnk_d = sda_s;
          end else if (scl_fall) begin
            state_d  = ST_HOLD;
            evt_byte = 1'b1;
          end
        end
        ST_HOLD: begin
          if (tx_mode && data_wr) begin
            state_d = ST_TX;
            shf_d   = wdata;
            cnt_d   = '0;
            sda_d   = ~wdata[DATA_W-1];
          end else if (!tx_mode && data_rd) begin
            state_d = ST_RX;
            cnt_d   = '0;
            sda_d   = 1'b0;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shf_q   <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      rxnk_q  <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shf_q   <= shf_d;
      data_q  <= data_d;
      busy_q  <= busy_d;
      dir_q   <= dir_d;
      rxnk_q  <= rxnk_d;
      sda_q   <= sda_d;
    end
  end

  assign busy     = busy_q;
  assign dir      = dir_q;
  assign rx_nack  = rxnk_q;
  assign evt_stop = stop_p;
  assign sda_oe   = sda_q;
  assign scl_oe   = (state_q == ST_HOLD);

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> busy_q);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (!busy_q && !sda_oe && !scl_oe));

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> (!sda_q && !scl_oe));

  assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) && !start_p && !stop_p &&
    ((tx_mode && data_wr) || (!tx_mode && data_rd)) |=> !scl_oe);

  assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_q != $past(sda_q)) && !$past(start_p) && !$past(stop_p) |-> !$past(scl_s));

  assert_tack_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TACK) |-> !sda_q);

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-2:0] OWN_RST = 7'h2A,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] wbits,
  input  logic [DATA_W-1:0] data_q,
  input  logic              busy,
  input  logic              dir,
  input  logic              rx_nack,
  input  logic              holding,
  input  logic              evt_addr,
  input  logic              evt_byte,
  input  logic              evt_stop,
  output logic [ADDR_W-1:0] own_addr,
  output logic              tx_mode,
  output logic              nack_ctl,
  output logic              data_wr,
  output logic              data_rd,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] own_q, own_d;
  logic              txm_q, txm_d;
  logic              nak_q, nak_d;
  logic              irq_q, irq_d;
  logic              hit_q, hit_d;
  logic              wr_ctrl, wr_stat, wr_own;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign wr_stat = reg_wr && (reg_addr == REG_STAT);
  assign wr_own  = reg_wr && (reg_addr == REG_OWN);
  assign data_wr = reg_wr && (reg_addr == REG_DATA);
  assign data_rd = reg_rd && (reg_addr == REG_DATA);

  always_comb begin
    own_d = own_q;
    txm_d = txm_q;
    nak_d = nak_q;
    irq_d = irq_q;
    hit_d = hit_q;
    if (wr_own) begin
      own_d = wbits;
    end
    if (wr_ctrl) begin
      txm_d = wbits[CTRL_TXM];
      nak_d = wbits[CTRL_NACK];
    end
    if (wr_stat && wbits[SB_IRQ]) begin
      irq_d = 1'b0;
    end
    if (evt_addr || evt_byte) begin
      irq_d = 1'b1;
    end
    if (evt_addr) begin
      hit_d = 1'b1;
    end else if (evt_byte || evt_stop) begin
      hit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_RST;
      txm_q <= 1'b0;
      nak_q <= 1'b0;
      irq_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      own_q <= own_d;
      txm_q <= txm_d;
      nak_q <= nak_d;
      irq_q <= irq_d;
      hit_q <= hit_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (reg_addr)
      REG_CTRL: begin
        rdata[CTRL_TXM]  = txm_q;
        rdata[CTRL_NACK] = nak_q;
      end
      REG_STAT: begin
        rdata[SB_BUSY] = busy;
        rdata[SB_HIT]  = hit_q;
        rdata[SB_DIR]  = dir;
        rdata[SB_RXNK] = rx_nack;
        rdata[SB_IRQ]  = irq_q;
        rdata[SB_HOLD] = holding;
      end
      REG_DATA: rdata = data_q;
      default:  rdata[ADDR_W-1:0] = own_q;
    endcase
  end

  assign own_addr = own_q;
  assign tx_mode  = txm_q;
  assign nack_ctl = nak_q;
  assign irq      = irq_q;

  assert_addr_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr |=> (irq_q && hit_q));

  assert_byte_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_byte |=> (irq_q && !hit_q));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[SB_IRQ] && !evt_addr && !evt_byte) |=> !irq_q);

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] OWN_RST = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int ADDR_W = DATA_W - 1;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [1:0]        lvl, rise, fall;
  logic [ADDR_W-1:0] own_addr;
  logic              tx_mode, nack_ctl, data_wr, data_rd;
  logic [DATA_W-1:0] data_q;
  logic              busy, dir, rx_nack;
  logic              evt_addr, evt_byte, evt_stop;
  logic              scl_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({sda_i, scl_i}),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  i2cs_engine #(.DATA_W(DATA_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .scl_s    (lvl[0]),
    .sda_s    (lvl[1]),
    .scl_rise (rise[0]),
    .scl_fall (fall[0]),
    .sda_rise (rise[1]),
    .sda_fall (fall[1]),
    .own_addr (own_addr),
    .tx_mode  (tx_mode),
    .nack_ctl (nack_ctl),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .wdata    (reg_wdata),
    .data_q   (data_q),
    .busy     (busy),
    .dir      (dir),
    .rx_nack  (rx_nack),
    .evt_addr (evt_addr),
    .evt_byte (evt_byte),
    .evt_stop (evt_stop),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_hold)
  );

  i2cs_regs #(.DATA_W(DATA_W), .OWN_RST(OWN_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .wbits    (reg_wdata[ADDR_W-1:0]),
    .data_q   (data_q),
    .busy     (busy),
    .dir      (dir),
    .rx_nack  (rx_nack),
    .holding  (scl_hold),
    .evt_addr (evt_addr),
    .evt_byte (evt_byte),
    .evt_stop (evt_stop),
    .own_addr (own_addr),
    .tx_mode  (tx_mode),
    .nack_ctl (nack_ctl),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .irq      (irq),
    .rdata    (reg_rdata)
  );

  assign scl_oe = scl_hold;

endmodule

// File: tb/tb_i2c_slave_ctrl.sv
module tb_i2c_slave_ctrl;

  localparam int Q = 12;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_OWN  = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic scl_i, sda_i, scl_oe, sda_oe;
  logic [1:0] reg_addr;
  logic reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_i = scl_m & ~scl_oe;
  assign sda_i = sda_m & ~sda_oe;

  i2c_slave_ctrl dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] exp_stat(input logic busy, hit, dir, nack, irqp, hold);
    return {2'b00, hold, irqp, nack, dir, hit, busy};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (!scl_i) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hwait();
    scl_up(); hwait();
    sda_m = 1'b0; hwait();
    scl_m = 1'b0; hwait();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hwait();
    scl_up(); hwait();
    sda_m = 1'b1; hwait();
  endtask

  task automatic m_bit_w(input logic b);
    sda_m = b; hwait();
    scl_up(); hwait();
    scl_m = 1'b0; hwait();
  endtask

  task automatic m_bit_r(output logic b);
    sda_m = 1'b1; hwait();
    scl_up(); hwait();
    b = sda_i;
    scl_m = 1'b0; hwait();
  endtask

  task automatic m_byte_w(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    m_bit_r(ack);
  endtask

  task automatic m_byte_r(output logic [7:0] v, input logic ackbit);
    for (int i = 7; i >= 0; i--) m_bit_r(v[i]);
    m_bit_w(ackbit);
  endtask

  task automatic rw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_write(input logic [6:0] own, input int n);
    logic ack;
    logic [7:0] d, b;
    rw(A_OWN, {1'b0, own});
    rr(A_OWN, d);            chk("R3 own address readback", d, {1'b0, own});
    rw(A_CTRL, 8'h00);
    m_start();
    rr(A_STAT, d);           chk("R1 busy after START", d, exp_stat(1, 0, 0, 0, 0, 0));
    m_byte_w({own, 1'b0}, ack);
    chk("R3 address ack", ack, 0);
    chk("R5 irq on match", irq, 1);
    chk("R7 SCL held after address", scl_oe, 1);
    rr(A_STAT, d);           chk("R4 R5 status after write match", d, exp_stat(1, 1, 0, 0, 1, 1));
    rw(A_STAT, 8'h10);
    chk("R5 irq cleared", irq, 0);
    chk("R7 status write keeps hold", scl_oe, 1);
    rw(A_DATA, 8'h5A);
    chk("R7 data write in receive mode keeps hold", scl_oe, 1);
    rr(A_DATA, d);
    chk("R7 dummy read releases SCL", scl_oe, 0);
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      m_byte_w(b, ack);
      chk("R6 receive ack low", ack, 0);
      chk("R7 SCL held after byte", scl_oe, 1);
      rr(A_STAT, d);         chk("R5 byte event status", d, exp_stat(1, 0, 0, 0, 1, 1));
      rw(A_STAT, 8'h10);
      rr(A_DATA, d);         chk("R6 received byte", d, b);
    end
    rw(A_CTRL, 8'h02);
    b = 8'($urandom);
    m_byte_w(b, ack);
    chk("R6 receive nack when control bit 1 set", ack, 1);
    rw(A_STAT, 8'h10);
    rr(A_DATA, d);           chk("R6 byte stored with nack", d, b);
    m_stop();
    rr(A_STAT, d);           chk("R2 status after STOP", d, exp_stat(0, 0, 0, 0, 0, 0));
    chk("R2 SDA released", sda_oe, 0);
    chk("R2 SCL released", scl_oe, 0);
    rw(A_CTRL, 8'h00);
  endtask

  initial begin
    logic ack;
    logic [7:0] d, b, prev;
    logic [6:0] own, other;
    void'($urandom(32'h1D2C3B4A));
    scl_m = 1'b1; sda_m = 1'b1;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk("R11 sda_oe reset", sda_oe, 0);
    chk("R11 scl_oe reset", scl_oe, 0);
    chk("R11 irq reset", irq, 0);
    rr(A_STAT, d);  chk("R11 status reset", d, 0);
    rr(A_CTRL, d);  chk("R11 control reset", d, 0);
    rr(A_OWN, d);   chk("R11 own address reset", d, 8'h2A);

    for (int r = 0; r < 3; r++) begin
      own = 7'($urandom);
      run_write(own, 2 + int'($urandom % 3));
    end

    own = 7'h2A ^ 7'($urandom);
    rw(A_OWN, {1'b0, own});
    other = own ^ (7'd1 << ($urandom % 7));
    m_start();
    m_byte_w({other, 1'b0}, ack);
    chk("R3 mismatch no ack", ack, 1);
    chk("R3 mismatch no irq", irq, 0);
    chk("R3 mismatch no hold", scl_oe, 0);
    m_byte_w(8'($urandom), ack);
    chk("R3 byte after mismatch ignored", ack, 1);
    chk("R3 no irq after ignored byte", irq, 0);
    m_stop();
    rr(A_STAT, d);  chk("R2 status after mismatch STOP", d, 0);

    m_start();
    m_byte_w({own, 1'b1}, ack);
    chk("R3 read address ack", ack, 0);
    rr(A_STAT, d);  chk("R4 direction bit read", d, exp_stat(1, 1, 1, 0, 1, 1));
    rw(A_STAT, 8'h10);
    rw(A_CTRL, 8'h01);
    rr(A_DATA, d);
    chk("R7 read in transmit mode keeps hold", scl_oe, 1);
    for (int k = 0; k < 3; k++) begin
      logic last;
      last = (k == 2);
      b = 8'($urandom);
      rw(A_DATA, b);
      chk("R7 data write in transmit mode releases", scl_oe, 0);
      m_byte_r(d, last);
      chk("R8 transmitted byte", d, b);
      chk("R9 SDA released after ack clock", sda_oe, 0);
      chk("R7 SCL held after sent byte", scl_oe, 1);
      rr(A_STAT, prev); chk("R9 master ack status", prev, exp_stat(1, 0, 1, last, 1, 1));
      rw(A_STAT, 8'h10);
    end
    rw(A_CTRL, 8'h00);
    rr(A_DATA, prev);
    chk("R7 dummy read after nack releases", scl_oe, 0);
    m_stop();
    rr(A_STAT, d);  chk("R2 status after read STOP", d, 0);

    m_start();
    m_byte_w({own, 1'b0}, ack);
    chk("R3 ack before restart", ack, 0);
    rw(A_STAT, 8'h10);
    rr(A_DATA, prev);
    for (int i = 0; i < 3; i++) m_bit_w(1'($urandom));
    m_start();
    chk("R10 no hold after restart", scl_oe, 0);
    chk("R10 no irq after restart", irq, 0);
    m_byte_w({own, 1'b0}, ack);
    chk("R10 address ack after restart", ack, 0);
    rr(A_STAT, d);  chk("R10 status after restart match", d, exp_stat(1, 1, 0, 0, 1, 1));
    rw(A_STAT, 8'h10);
    rr(A_DATA, d);  chk("R10 data register unchanged", d, prev);
    m_stop();
    rr(A_STAT, d);  chk("R2 status after final STOP", d, 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 to R11 run did not complete actual=hang expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule